// File: doc/BRIEF.md
# Fused Multiply-Add NaN Arbiter

This block decides which operand of a fused multiply-add `(a*b)+c` becomes the result once at least one operand is a NaN. It takes a two-bit class code for each of the three operands. It also takes a flag that marks the invalid product infinity times zero, and a three-bit policy select. From these it returns a two-bit result code that names operand a, b or c, or asks for the default NaN, together with an invalid-operation flag. The block is purely combinational and settles within the cycle in which its inputs change.

Several propagation policies are built in. They differ in three ways. Some rank signaling NaNs ahead of quiet ones and some look only for any NaN. They scan the operands in different orders, including orders that start from the addend c. They also treat the infinity-times-zero product differently: one policy returns the default NaN only when c is quiet, some always return the default NaN, and some hand back c. The arithmetic, the quieting of a chosen signaling NaN and the building of the default NaN pattern belong to the surrounding datapath.

Top module: `fma_nan_arbiter`

## Requirements
- R1: Class codes are 2'b00 = not a NaN, 2'b01 = quiet NaN, 2'b10 = signaling NaN, and 2'b11 = treated as not a NaN. The result codes are 0 = a, 1 = b, 2 = c and 3 = default NaN. When no operand is a NaN, the result is 3 under every policy.
- R2: `raise_invalid` is 1 whenever any operand is signaling, under every policy.
- R3: Policy 0 with `inf_times_zero` = 1 and c quiet returns 3 and raises invalid. Under policy 0, `inf_times_zero` raises nothing when c is not quiet.
- R4: Otherwise policy 0 scans in this order: signaling c, signaling a, signaling b, quiet c, quiet a, and falls back to b.
- R5: Policy 1 with `inf_times_zero` returns 3 and raises invalid. Otherwise it picks signaling a, b or c first, then quiet a, then quiet b, then c.
- R6: Policy 2 with `inf_times_zero` returns 2 and raises invalid. Otherwise it picks signaling c, a or b first, then quiet c, then quiet a, then b.
- R7: Policy 3 with `inf_times_zero` returns 2 and raises invalid. Otherwise it returns a if a is any NaN, else c if c is any NaN, else b.
- R8: Policies 4 and 7 always return 3. They raise invalid when `inf_times_zero` is 1.
- R9: Policy 5 with `inf_times_zero` returns 2 and raises invalid. Otherwise it returns the first NaN in the order a, b, c.
- R10: Policy 6 with `inf_times_zero` returns 2 and raises invalid. Otherwise it returns the first NaN in the order c, b, a.
- R11: Under policies 2, 3, 5 and 6, the `inf_times_zero` rule overrides the NaN ordering whenever at least one operand is a NaN, even when the NaN is signaling and sits in a or b.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a_cls | input | 2 | Class code of multiplicand a |
| op_b_cls | input | 2 | Class code of multiplicand b |
| op_c_cls | input | 2 | Class code of addend c |
| inf_times_zero | input | 1 | Multiplicands are infinity and zero |
| policy | input | 3 | Propagation policy select, 0 to 7 |
| pick | output | 2 | Result code: 0 a, 1 b, 2 c, 3 default NaN |
| raise_invalid | output | 1 | Invalid-operation flag |

## Verification
The block holds no state, so any fault in the policy table or the ordering logic shows at `pick` or `raise_invalid` within the same cycle as the input pattern that exposes it. A wrong entry in the scan order reveals itself only when two or more operands are NaNs of competing classes. For that reason every policy is swept over all class and flag combinations and compared against a model written from the requirements. A mis-ranked signaling tier shows when a quiet NaN sits earlier in the order than a signaling one.

// File: rtl/fma_nan_pkg.sv
// Package: shared types for the FMA NaN arbiter.
// Assumes operand indices double as result codes (0 a, 1 b, 2 c).
package fma_nan_pkg;

    localparam int unsigned N_OPS   = 3;
    localparam int unsigned CLS_W   = 2;
    localparam int unsigned CODE_W  = 2;
    localparam int unsigned POL_W   = 3;

    typedef logic [CODE_W-1:0] op_idx_t;

    localparam op_idx_t IDX_A       = 2'd0;
    localparam op_idx_t IDX_B       = 2'd1;
    localparam op_idx_t IDX_C       = 2'd2;
    localparam op_idx_t CODE_DFLT   = 2'd3;

    localparam logic [CLS_W-1:0] CLS_QUIET = 2'b01;
    localparam logic [CLS_W-1:0] CLS_SIGN  = 2'b10;

    // How the infinity-times-zero product is handled
    typedef enum logic [1:0] {
        IZ_DFLT_IF_CQ = 2'd0,   // default NaN only when c is quiet
        IZ_DFLT       = 2'd1,   // always default NaN
        IZ_TAKE_C     = 2'd2    // hand back operand c
    } iz_mode_e;

    typedef struct packed {
        op_idx_t  first;
        op_idx_t  second;
        op_idx_t  third;
        logic     two_tier;     // rank signaling NaNs ahead of quiet ones
        iz_mode_e iz_mode;
        logic     force_dflt;   // result is always the default NaN
    } pol_cfg_t;

endpackage

// File: rtl/fma_nan_classify.sv
// Module: fma_nan_classify
// Turns the per-operand class codes into signaling, quiet and any-NaN
// vectors, indexed 0 = a, 1 = b, 2 = c. Code 2'b11 counts as non-NaN.
module fma_nan_classify
    import fma_nan_pkg::*;
(
    input  logic [N_OPS*CLS_W-1:0] cls_flat,
    output logic [N_OPS-1:0]       is_sig,
    output logic [N_OPS-1:0]       is_qui,
    output logic [N_OPS-1:0]       is_nan
);

    for (genvar g = 0; g < N_OPS; g++) begin : g_op
        logic [CLS_W-1:0] code;
        assign code = cls_flat[g*CLS_W +: CLS_W];

        // Decode one operand class
        always_comb begin
            is_sig[g] = (code == CLS_SIGN);
            is_qui[g] = (code == CLS_QUIET);
            is_nan[g] = is_sig[g] | is_qui[g];
        end
    end

endmodule

// File: rtl/fma_nan_policy_table.sv
// Module: fma_nan_policy_table
// Maps the policy select to a scan order, a tier mode and an
// infinity-times-zero rule. Unlisted selects behave as always-default.
module fma_nan_policy_table
    import fma_nan_pkg::*;
(
    input  logic [POL_W-1:0] policy,
    output pol_cfg_t         cfg
);

    // Look up the configuration of the selected policy
    always_comb begin
        cfg = '{first: IDX_A, second: IDX_B, third: IDX_C, two_tier: 1'b0,
                iz_mode: IZ_DFLT, force_dflt: 1'b1};
        unique case (policy)
            3'd0: cfg = '{first: IDX_C, second: IDX_A, third: IDX_B,
                          two_tier: 1'b1, iz_mode: IZ_DFLT_IF_CQ, force_dflt: 1'b0};
            3'd1: cfg = '{first: IDX_A, second: IDX_B, third: IDX_C,
                          two_tier: 1'b1, iz_mode: IZ_DFLT, force_dflt: 1'b0};
            3'd2: cfg = '{first: IDX_C, second: IDX_A, third: IDX_B,
                          two_tier: 1'b1, iz_mode: IZ_TAKE_C, force_dflt: 1'b0};
            3'd3: cfg = '{first: IDX_A, second: IDX_C, third: IDX_B,
                          two_tier: 1'b0, iz_mode: IZ_TAKE_C, force_dflt: 1'b0};
            3'd5: cfg = '{first: IDX_A, second: IDX_B, third: IDX_C,
                          two_tier: 1'b0, iz_mode: IZ_TAKE_C, force_dflt: 1'b0};
            3'd6: cfg = '{first: IDX_C, second: IDX_B, third: IDX_A,
                          two_tier: 1'b0, iz_mode: IZ_TAKE_C, force_dflt: 1'b0};
            default: ;
        endcase
    end

endmodule

// File: rtl/fma_nan_order_pick.sv
// Module: fma_nan_order_pick
// Walks the operands in the configured order. It takes the first
// signaling NaN when two-tier ranking is on, otherwise (or failing that)
// the first NaN of any kind. When nothing matches it falls back to the
// last operand in the order.
module fma_nan_order_pick
    import fma_nan_pkg::*;
(
    input  pol_cfg_t         cfg,
    input  logic [N_OPS-1:0] is_sig,
    input  logic [N_OPS-1:0] is_nan,
    output op_idx_t          sel
);

    op_idx_t          order [N_OPS];
    logic [N_OPS-1:0] hit_sig;
    logic [N_OPS-1:0] hit_nan;

    // Unpack the scan order
    always_comb begin
        order[0] = cfg.first;
        order[1] = cfg.second;
        order[2] = cfg.third;
    end

    for (genvar k = 0; k < N_OPS; k++) begin : g_slot
        logic [N_OPS-1:0] onehot;
        // Route the operand at scan slot k to its hit flags
        always_comb begin
            onehot     = '0;
            for (int j = 0; j < N_OPS; j++) begin
                onehot[j] = (order[k] == op_idx_t'(j));
            end
            hit_sig[k] = cfg.two_tier & |(onehot & is_sig);
            hit_nan[k] = |(onehot & is_nan);
        end
    end

    // Priority scan: signaling tier, then any-NaN tier, then fallback
    always_comb begin
        logic done;
        sel  = order[N_OPS-1];
        done = 1'b0;
        for (int k = 0; k < N_OPS; k++) begin
            if (!done && hit_sig[k]) begin
                sel  = order[k];
                done = 1'b1;
            end
        end
        for (int k = 0; k < N_OPS; k++) begin
            if (!done && hit_nan[k]) begin
                sel  = order[k];
                done = 1'b1;
            end
        end
    end

endmodule

// File: rtl/fma_nan_arbiter.sv
// Module: fma_nan_arbiter (top)
// Combinational NaN source selection for a fused multiply-add.
// Assumes the caller quiets a chosen signaling NaN and builds the default
// NaN. With no NaN operand the result code is the default-NaN code.
module fma_nan_arbiter
    import fma_nan_pkg::*;
(
    input  logic [1:0] op_a_cls,
    input  logic [1:0] op_b_cls,
    input  logic [1:0] op_c_cls,
    input  logic       inf_times_zero,
    input  logic [2:0] policy,
    output logic [1:0] pick,
    output logic       raise_invalid
);

    logic [N_OPS-1:0] is_sig;
    logic [N_OPS-1:0] is_qui;
    logic [N_OPS-1:0] is_nan;
    pol_cfg_t         cfg;
    op_idx_t          ordered_sel;
    logic             iz_hits;

    fma_nan_classify u_classify (
        .cls_flat ({op_c_cls, op_b_cls, op_a_cls}),
        .is_sig   (is_sig),
        .is_qui   (is_qui),
        .is_nan   (is_nan)
    );

    fma_nan_policy_table u_table (
        .policy (policy),
        .cfg    (cfg)
    );

    fma_nan_order_pick u_pick (
        .cfg    (cfg),
        .is_sig (is_sig),
        .is_nan (is_nan),
        .sel    (ordered_sel)
    );

    // Decide whether the infinity-times-zero rule applies under this policy
    always_comb begin
        if (cfg.iz_mode == IZ_DFLT_IF_CQ) begin
            iz_hits = inf_times_zero & is_qui[IDX_C];
        end else begin
            iz_hits = inf_times_zero;
        end
    end

    // Combine ordering, special-case overrides and the no-NaN default
    always_comb begin
        pick = ordered_sel;
        if (cfg.force_dflt) begin
            pick = CODE_DFLT;
        end else if (iz_hits) begin
            pick = (cfg.iz_mode == IZ_TAKE_C) ? IDX_C : CODE_DFLT;
        end
        if (is_nan == '0) begin
            pick = CODE_DFLT;
        end
    end

    // Raise invalid on any signaling operand or an applicable inf*0 product
    always_comb begin
        raise_invalid = (|is_sig) | iz_hits;
    end

endmodule

// File: rtl/fma_nan_arbiter_chk.sv
// Module: fma_nan_arbiter_chk
// Port-level consistency checks for fma_nan_arbiter, attached by bind.
module fma_nan_arbiter_chk (
    input logic [1:0] op_a_cls,
    input logic [1:0] op_b_cls,
    input logic [1:0] op_c_cls,
    input logic       inf_times_zero,
    input logic [2:0] policy,
    input logic [1:0] pick,
    input logic       raise_invalid
);

    logic any_sig;
    logic any_nan;
    logic picked_nan;
    logic known;

    // Derive port-level summaries for the checks
    always_comb begin
        any_sig = (op_a_cls == 2'b10) | (op_b_cls == 2'b10) | (op_c_cls == 2'b10);
        any_nan = any_sig | (op_a_cls == 2'b01) | (op_b_cls == 2'b01)
                | (op_c_cls == 2'b01);
        case (pick)
            2'd0:    picked_nan = (op_a_cls == 2'b01) | (op_a_cls == 2'b10);
            2'd1:    picked_nan = (op_b_cls == 2'b01) | (op_b_cls == 2'b10);
            2'd2:    picked_nan = (op_c_cls == 2'b01) | (op_c_cls == 2'b10);
            default: picked_nan = 1'b0;
        endcase
        known = !$isunknown({op_a_cls, op_b_cls, op_c_cls, inf_times_zero,
                             policy, pick, raise_invalid});
    end

    // Evaluate the immediate checks once all ports carry known values
    always_comb begin
        if (known) begin
            AST_SIG_RAISES_INVALID: assert (!any_sig || raise_invalid) else $error("sig without invalid"); // R2
            AST_NO_NAN_GIVES_DEFAULT: assert (any_nan || pick == 2'd3) else $error("no NaN but operand pick"); // R1
            AST_FORCED_DEFAULT: assert (!(policy == 3'd4 || policy == 3'd7) || pick == 2'd3) else $error("forced policy picked operand"); // R8
            AST_PICK_IS_NAN: assert (inf_times_zero || pick == 2'd3 || picked_nan) else $error("picked a non-NaN operand"); // R4
            AST_IZ_TAKES_C: assert (!(inf_times_zero && any_nan && (policy == 3'd2 || policy == 3'd3 || policy == 3'd5 || policy == 3'd6)) || (pick == 2'd2 && raise_invalid)) else $error("inf*0 did not take c"); // R11
        end
    end

endmodule

bind fma_nan_arbiter fma_nan_arbiter_chk u_chk (.*);

// File: tb/test_fma_nan_arbiter.sv
// Directed bench for fma_nan_arbiter: one task per scenario.
module test_fma_nan_arbiter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] op_a_cls = 2'b00;
    logic [1:0] op_b_cls = 2'b00;
    logic [1:0] op_c_cls = 2'b00;
    logic       inf_times_zero = 1'b0;
    logic [2:0] policy = 3'd0;
    logic [1:0] pick;
    logic       raise_invalid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    fma_nan_arbiter i_fma_nan_arbiter (
        .op_a_cls       (op_a_cls),
        .op_b_cls       (op_b_cls),
        .op_c_cls       (op_c_cls),
        .inf_times_zero (inf_times_zero),
        .policy         (policy),
        .pick           (pick),
        .raise_invalid  (raise_invalid)
    );

    // Reference written from the requirements: returns {invalid, pick}
    function automatic logic [2:0] model(input logic [1:0] ca, cb, cc,
                                         input logic iz, input logic [2:0] p);
        logic sa, sb, sc, qa, qb, qc, na, nb, nc, inv;
        logic [1:0] r;
        sa = (ca == 2'b10); sb = (cb == 2'b10); sc = (cc == 2'b10);
        qa = (ca == 2'b01); qb = (cb == 2'b01); qc = (cc == 2'b01);
        na = sa | qa; nb = sb | qb; nc = sc | qc;
        inv = sa | sb | sc;
        r = 2'd3;
        case (p)
            3'd0: if (iz && qc) begin inv = 1'b1; r = 2'd3; end
                  else if (sc) r = 2'd2; else if (sa) r = 2'd0; else if (sb) r = 2'd1;
                  else if (qc) r = 2'd2; else if (qa) r = 2'd0; else r = 2'd1;
            3'd1: if (iz) begin inv = 1'b1; r = 2'd3; end
                  else if (sa) r = 2'd0; else if (sb) r = 2'd1; else if (sc) r = 2'd2;
                  else if (qa) r = 2'd0; else if (qb) r = 2'd1; else r = 2'd2;
            3'd2: if (iz) begin inv = 1'b1; r = 2'd2; end
                  else if (sc) r = 2'd2; else if (sa) r = 2'd0; else if (sb) r = 2'd1;
                  else if (qc) r = 2'd2; else if (qa) r = 2'd0; else r = 2'd1;
            3'd3: if (iz) begin inv = 1'b1; r = 2'd2; end
                  else if (na) r = 2'd0; else if (nc) r = 2'd2; else r = 2'd1;
            3'd5: if (iz) begin inv = 1'b1; r = 2'd2; end
                  else if (na) r = 2'd0; else if (nb) r = 2'd1; else r = 2'd2;
            3'd6: if (iz) begin inv = 1'b1; r = 2'd2; end
                  else if (nc) r = 2'd2; else if (nb) r = 2'd1; else r = 2'd0;
            default: begin if (iz) inv = 1'b1; r = 2'd3; end
        endcase
        if (!(na | nb | nc)) r = 2'd3;
        return {inv, r};
    endfunction

    // Drive one pattern, then sample at the following falling edge
    task automatic apply(input logic [1:0] ca, cb, cc, input logic iz,
                         input logic [2:0] p);
        @(posedge clk);
        op_a_cls = ca; op_b_cls = cb; op_c_cls = cc;
        inf_times_zero = iz; policy = p;
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [1:0] exp_pick,
                         input logic exp_inv);
        checks++;
        if (pick !== exp_pick || raise_invalid !== exp_inv) begin
            errors++;
            $display("FAIL %s a=%0d b=%0d c=%0d iz=%0d pol=%0d: pick=%0d inv=%0d expected pick=%0d inv=%0d",
                     tag, op_a_cls, op_b_cls, op_c_cls, inf_times_zero, policy,
                     pick, raise_invalid, exp_pick, exp_inv);
        end
    endtask

    task automatic apply_model(input string tag, input logic [1:0] ca, cb, cc,
                               input logic iz, input logic [2:0] p);
        logic [2:0] e;
        apply(ca, cb, cc, iz, p);
        e = model(ca, cb, cc, iz, p);
        check(tag, e[1:0], e[2]);
    endtask

    // Idle inputs after reset: no NaN gives default code, no invalid (R1)
    task automatic t_reset_idle();
        apply(2'b00, 2'b00, 2'b00, 1'b0, 3'd0);
        check("R1 idle", 2'd3, 1'b0);
        apply(2'b11, 2'b11, 2'b11, 1'b0, 3'd5);
        check("R1 code11 non-NaN", 2'd3, 1'b0);
    endtask

    // Result encoding with a single NaN operand (R1)
    task automatic t_encoding();
        apply(2'b01, 2'b00, 2'b00, 1'b0, 3'd5); check("R1 a", 2'd0, 1'b0);
        apply(2'b00, 2'b01, 2'b00, 1'b0, 3'd5); check("R1 b", 2'd1, 1'b0);
        apply(2'b00, 2'b00, 2'b01, 1'b0, 3'd5); check("R1 c", 2'd2, 1'b0);
    endtask

    // Any signaling operand raises invalid under every policy (R2)
    task automatic t_sig_invalid();
        for (int p = 0; p < 8; p++) begin
            apply(2'b00, 2'b10, 2'b00, 1'b0, 3'(p));
            checks++;
            if (raise_invalid !== 1'b1) begin
                errors++;
                $display("FAIL R2 pol=%0d inv=%0d expected 1", p, raise_invalid);
            end
        end
    endtask

    // Policy 0 inf*0 corner cases (R3)
    task automatic t_pol0_iz();
        apply(2'b01, 2'b00, 2'b01, 1'b1, 3'd0); check("R3 cq", 2'd3, 1'b1);
        apply(2'b01, 2'b00, 2'b00, 1'b1, 3'd0); check("R3 c not NaN", 2'd0, 1'b0);
        apply(2'b00, 2'b00, 2'b10, 1'b1, 3'd0); check("R3 c sig", 2'd2, 1'b1);
    endtask

    // Full sweep of one policy over every class and flag combination
    task automatic t_sweep(input string tag, input logic [2:0] p);
        for (int v = 0; v < 128; v++) begin
            apply_model(tag, 2'(v), 2'(v >> 2), 2'(v >> 4), v[6], p);
        end
    endtask

    // Priority corner cases: quiet ahead of signaling in scan order (R4..R10)
    task automatic t_tiers();
        apply(2'b01, 2'b00, 2'b10, 1'b0, 3'd1); check("R5 sig c beats quiet a", 2'd2, 1'b1);
        apply(2'b10, 2'b00, 2'b01, 1'b0, 3'd0); check("R4 sig a beats quiet c", 2'd0, 1'b1);
        apply(2'b10, 2'b00, 2'b01, 1'b0, 3'd6); check("R10 c first", 2'd2, 1'b1);
        apply(2'b00, 2'b01, 2'b01, 1'b0, 3'd3); check("R7 c over b", 2'd2, 1'b0);
        apply(2'b00, 2'b10, 2'b01, 1'b0, 3'd5); check("R9 b over c", 2'd1, 1'b1);
        apply(2'b01, 2'b10, 2'b00, 1'b0, 3'd2); check("R6 sig b over quiet a", 2'd1, 1'b1);
    endtask

    // inf*0 overrides ordering under policies 2, 3, 5, 6 (R11, R8)
    task automatic t_iz_override();
        apply(2'b10, 2'b00, 2'b00, 1'b1, 3'd2); check("R11 pol2", 2'd2, 1'b1);
        apply(2'b01, 2'b00, 2'b00, 1'b1, 3'd3); check("R11 pol3", 2'd2, 1'b1);
        apply(2'b00, 2'b10, 2'b00, 1'b1, 3'd5); check("R11 pol5", 2'd2, 1'b1);
        apply(2'b01, 2'b01, 2'b00, 1'b1, 3'd6); check("R11 pol6", 2'd2, 1'b1);
        apply(2'b01, 2'b00, 2'b00, 1'b1, 3'd4); check("R8 pol4 iz", 2'd3, 1'b1);
        apply(2'b01, 2'b00, 2'b00, 1'b0, 3'd7); check("R8 pol7", 2'd3, 1'b0);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        t_reset_idle();
        t_encoding();
        t_sig_invalid();
        t_pol0_iz();
        t_tiers();
        t_iz_override();
        t_sweep("R4 pol0", 3'd0);
        t_sweep("R5 pol1", 3'd1);
        t_sweep("R6 pol2", 3'd2);
        t_sweep("R7 pol3", 3'd3);
        t_sweep("R8 pol4", 3'd4);
        t_sweep("R9 pol5", 3'd5);
        t_sweep("R10 pol6", 3'd6);
        t_sweep("R8 pol7", 3'd7);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule